// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block is a synchronous controller for a 14-bit sampling converter with a parallel output. It drives the converter's four active-low control pins (chip select, convert start, read, power-down) and watches its active-low busy line. When the user pulses `start_i` while the controller is ready, it lowers chip select and waits a setup time. It then pulls convert start low for a bounded window and releases it, and waits for busy to return high. Finally it reads the two's-complement word and delivers it sign-extended to 16 bits with a one-cycle valid strobe. Every timing is a parameter in clock cycles. The defaults round the converter's nanosecond limits up to whole cycles of a 100 MHz clock.

The power-mode request `pmode_i` uses 0 for run, 1 for nap and 2 for sleep, and 3 counts as run. A power-down request settles chip select before power-down falls: low selects nap and high selects sleep. On the return to run, the controller raises power-down and waits out a wake-up interval before it reports ready again. The busy input passes through a two-flop synchronizer, and only its synchronized rising edge ends a conversion. If that edge does not arrive within a timeout of about 1.5 times the longest conversion, a sticky error flag is set, all pins are released and the controller goes back to idle.

The states are IDLE, CS_SETUP, CONV_LOW, WAIT_BUSY, READ, RELEASE, PD_SELECT, PD_HOLD and WAKE. The transitions are:
- IDLE to CS_SETUP on start while in run mode, and IDLE to PD_SELECT on a nap or sleep request.
- CS_SETUP to CONV_LOW, then CONV_LOW to WAIT_BUSY, each when its timer expires.
- WAIT_BUSY to READ on the synchronized busy rise, or WAIT_BUSY to IDLE on timeout.
- READ to RELEASE, then RELEASE to IDLE, each on its timer.
- PD_SELECT to PD_HOLD on its timer. PD_SELECT or PD_HOLD goes to WAKE when the request differs from the latched mode.
- WAKE to IDLE on its timer.

Top module: `adcseq_ctrl`

## Requirements
- R1: Out of reset, all four converter control outputs are high, `err_o` and `result_valid_o` are low, and `ready_o` is high while `pmode_i` requests run.
- R2: Convert start is low only while chip select is low. Chip select has been low for exactly CS_SETUP_CYC cycles when convert start falls.
- R3: Convert start stays low for exactly CONV_LOW_CYC cycles and is high again before the controller acts on the busy rise.
- R4: After convert start is released, the controller waits for the synchronized rising edge of busy and only then starts a read.
- R5: Read is low only while chip select is low, for exactly RD_ACCESS_CYC cycles, and the converter word is captured on the last of those cycles.
- R6: The result is the captured 14-bit word sign-extended to 16 bits (0x2000 gives 0xE000, 0x1FFF gives 0x1FFF). `result_valid_o` is high for exactly one cycle per conversion.
- R7: On a nap request chip select is low when power-down falls, and on a sleep request it is high. Chip select does not change while power-down is low, and convert start and read stay high throughout.
- R8: After power-down rises, `ready_o` stays low for exactly WAKE_CYC cycles before it returns high.
- R9: If busy does not rise within CONV_TMO_CYC cycles, `err_o` is set and stays set until reset, all control outputs go high, and later conversions still work.
- R10: A start pulse arriving while a conversion, a power-down or a wake-up is under way starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request pulse |
| pmode_i | input | 2 | Power mode: 0 run, 1 nap, 2 sleep, 3 run |
| ready_o | output | 1 | Idle in run mode, so a start will be accepted |
| result_o | output | 16 | Sign-extended conversion result |
| result_valid_o | output | 1 | One-cycle strobe marking a new result |
| err_o | output | 1 | Sticky busy-timeout flag |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_convst_n_o | output | 1 | Converter convert start, active low |
| adc_rd_n_o | output | 1 | Converter read enable, active low |
| adc_shdn_n_o | output | 1 | Converter power-down, active low |
| adc_busy_n_i | input | 1 | Converter busy, active low |
| adc_data_i | input | 14 | Converter parallel data, two's complement |

## Verification
The assertions assume that the converter lowers busy only after a convert-start fall and raises it once per conversion. They also assume that `pmode_i` holds steady for several cycles after each change, so a power-down choice is not reversed within the select window. The bench's converter stand-in lowers busy two cycles after it sees convert start fall, and raises it a fixed number of cycles later or, in the stuck case, only long after the timeout. The bench changes `pmode_i` and `start_i` only on falling clock edges, and every mode change is followed by a settle wait.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CS_SETUP,
        ST_CONV_LOW,
        ST_WAIT_BUSY,
        ST_READ,
        ST_RELEASE,
        ST_PD_SELECT,
        ST_PD_HOLD,
        ST_WAKE
    } seq_state_e;

    localparam logic [1:0] PM_NAP   = 2'd1;
    localparam logic [1:0] PM_SLEEP = 2'd2;

    function automatic logic is_pd_request(input logic [1:0] pm);
        return (pm == PM_NAP) || (pm == PM_SLEEP);
    endfunction

endpackage

// File: rtl/adcseq_busy_sync.sv
module adcseq_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_n_i,
    output logic busy_rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= 1'b1;
                end else if (i == 0) begin
                    chain_q[i] <= busy_n_i;
                end else begin
                    chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign busy_rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int DATA_W         = 14,
    parameter int RES_W          = 16,
    parameter int SYNC_STAGES    = 2,
    parameter int CS_SETUP_CYC   = 4,
    parameter int CONV_LOW_CYC   = 5,
    parameter int CONV_TMO_CYC   = 173,
    parameter int RD_ACCESS_CYC  = 5,
    parameter int RD_RELEASE_CYC = 2,
    parameter int WAKE_CYC       = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        pmode_i,
    output logic              ready_o,
    output logic [RES_W-1:0]  result_o,
    output logic              result_valid_o,
    output logic              err_o,
    output logic              adc_cs_n_o,
    output logic              adc_convst_n_o,
    output logic              adc_rd_n_o,
    output logic              adc_shdn_n_o,
    input  logic              adc_busy_n_i,
    input  logic [DATA_W-1:0] adc_data_i
);
    localparam int TMR_MAX = (CONV_TMO_CYC > WAKE_CYC) ? CONV_TMO_CYC : WAKE_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1) + 1;
    localparam int EXT_W   = RES_W - DATA_W;

    seq_state_e       state_q, state_d;
    logic [1:0]       pd_mode_q, pd_mode_d;
    logic             busy_rise, tmr_exp, tmr_load;
    logic [TMR_W-1:0] tmr_val;

    adcseq_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_n_i    (adc_busy_n_i),
        .busy_rise_o (busy_rise)
    );

    adcseq_timer #(.W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    function automatic logic [TMR_W-1:0] dwell(input seq_state_e s);
        unique case (s)
            ST_CS_SETUP, ST_PD_SELECT: return TMR_W'(CS_SETUP_CYC);
            ST_CONV_LOW:               return TMR_W'(CONV_LOW_CYC);
            ST_WAIT_BUSY:              return TMR_W'(CONV_TMO_CYC);
            ST_READ:                   return TMR_W'(RD_ACCESS_CYC);
            ST_RELEASE:                return TMR_W'(RD_RELEASE_CYC);
            ST_WAKE:                   return TMR_W'(WAKE_CYC);
            default:                   return TMR_W'(1);
        endcase
    endfunction

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        pd_mode_d = pd_mode_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_pd_request(pmode_i)) begin
                    state_d   = ST_PD_SELECT;
                    pd_mode_d = pmode_i;
                end else if (start_i) begin
                    state_d = ST_CS_SETUP;
                end
            end
            ST_CS_SETUP:  if (tmr_exp) state_d = ST_CONV_LOW;
            ST_CONV_LOW:  if (tmr_exp) state_d = ST_WAIT_BUSY;
            ST_WAIT_BUSY: begin
                if (busy_rise)    state_d = ST_READ;
                else if (tmr_exp) state_d = ST_IDLE;
            end
            ST_READ:      if (tmr_exp) state_d = ST_RELEASE;
            ST_RELEASE:   if (tmr_exp) state_d = ST_IDLE;
            ST_PD_SELECT: begin
                if (pmode_i != pd_mode_q) state_d = ST_WAKE;
                else if (tmr_exp)         state_d = ST_PD_HOLD;
            end
            ST_PD_HOLD:   if (pmode_i != pd_mode_q) state_d = ST_WAKE;
            ST_WAKE:      if (tmr_exp) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_d != state_q);
    assign tmr_val  = dwell(state_d);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pd_mode_q <= 2'd0;
        end else begin
            state_q   <= state_d;
            pd_mode_q <= pd_mode_d;
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_cs_n_o     <= 1'b1;
            adc_convst_n_o <= 1'b1;
            adc_rd_n_o     <= 1'b1;
            adc_shdn_n_o   <= 1'b1;
            result_o       <= '0;
            result_valid_o <= 1'b0;
            err_o          <= 1'b0;
        end else begin
            adc_cs_n_o     <= 1'b1;
            adc_convst_n_o <= 1'b1;
            adc_rd_n_o     <= 1'b1;
            adc_shdn_n_o   <= 1'b1;
            unique case (state_d)
                ST_CS_SETUP, ST_WAIT_BUSY, ST_RELEASE: adc_cs_n_o <= 1'b0;
                ST_CONV_LOW: begin
                    adc_cs_n_o     <= 1'b0;
                    adc_convst_n_o <= 1'b0;
                end
                ST_READ: begin
                    adc_cs_n_o <= 1'b0;
                    adc_rd_n_o <= 1'b0;
                end
                ST_PD_SELECT: adc_cs_n_o <= (pd_mode_d != PM_NAP);
                ST_PD_HOLD: begin
                    adc_cs_n_o   <= (pd_mode_d != PM_NAP);
                    adc_shdn_n_o <= 1'b0;
                end
                default: ;
            endcase
            result_valid_o <= (state_q == ST_READ) && tmr_exp;
            if ((state_q == ST_READ) && tmr_exp) begin
                result_o <= {{EXT_W{adc_data_i[DATA_W-1]}}, adc_data_i};
            end
            if ((state_q == ST_WAIT_BUSY) && !busy_rise && tmr_exp) begin
                err_o <= 1'b1;
            end
        end
    end

    assign ready_o = (state_q == ST_IDLE) && !is_pd_request(pmode_i);

    AST_CONVST_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_convst_n_o |-> !adc_cs_n_o); // R2
    AST_CONVST_RELEASED_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_rise && (state_q == ST_WAIT_BUSY) |-> adc_convst_n_o); // R3
    AST_READ_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n_o |-> !adc_cs_n_o); // R5
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o); // R6
    AST_CS_FROZEN_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_shdn_n_o |-> $stable(adc_cs_n_o)); // R7
    AST_PD_NO_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_shdn_n_o |-> (adc_convst_n_o && adc_rd_n_o)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R9
endmodule

// File: tb/adcseq_ctrl_test.sv
module adcseq_ctrl_test;
    localparam int CS_SETUP = 4, CONV_LOW = 5, RD_ACC = 5, WAKE = 40;
    localparam int CONV_T = 110, STUCK_T = 300;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] pmode = 2'd0;
    logic ready, valid, err, cs_n, cv_n, rd_n, sh_n;
    logic [15:0] result;
    logic busy_n = 1'b1;
    logic [13:0] data_bus, word = '0, sample_next = '0;

    int n_checks = 0, n_fail = 0, n_starts = 0, n_valid = 0, cyc = 0;
    bit done = 0, stuck = 0, converting = 0;
    int conv_cnt = 0;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    assign data_bus = (!cs_n && !rd_n) ? word : 14'h0;

    adcseq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pmode_i(pmode),
        .ready_o(ready), .result_o(result), .result_valid_o(valid), .err_o(err),
        .adc_cs_n_o(cs_n), .adc_convst_n_o(cv_n), .adc_rd_n_o(rd_n),
        .adc_shdn_n_o(sh_n), .adc_busy_n_i(busy_n), .adc_data_i(data_bus)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            check(0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // Behavioural converter stand-in
    logic cv_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cv_prev && !cv_n && !cs_n && sh_n && !converting) begin
                converting = 1; conv_cnt = 0; n_starts++;
            end
            if (converting) begin
                conv_cnt++;
                if (conv_cnt == 2) busy_n = 1'b0;
                if (!stuck && conv_cnt == CONV_T) begin
                    busy_n = 1'b1; word = sample_next;
                    exp_q.push_back({{2{sample_next[13]}}, sample_next});
                    converting = 0;
                end else if (stuck && conv_cnt == STUCK_T) begin
                    busy_n = 1'b1; converting = 0;
                end
            end
            cv_prev = cv_n;
        end
    end

    // Per-clock reference comparison on the pins
    logic m_cv = 1, m_rd = 1, m_sh = 1, m_valid = 0;
    int cs_run = 0, cv_run = 0, rd_run = 0, wake_cnt = 0;
    bit in_wake = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cv_n || !cs_n, "R2 convst under cs", cs_n, 0);
            check(rd_n || !cs_n, "R5 read under cs", cs_n, 0);
            if (m_cv && !cv_n) check(cs_run == CS_SETUP, "R2 cs setup", cs_run, CS_SETUP);
            if (!m_cv && cv_n) check(cv_run == CONV_LOW, "R3 convst width", cv_run, CONV_LOW);
            if (!m_rd && rd_n) check(rd_run == RD_ACC, "R5 read width", rd_run, RD_ACC);
            if (!sh_n) check(cv_n && rd_n, "R7 quiet in power-down", {cv_n, rd_n}, 3);
            if (m_sh && !sh_n)
                check(cs_n == (pmode == 2'd2), "R7 mode select", cs_n, pmode == 2'd2);
            if (valid) begin
                n_valid++;
                check(!m_valid, "R6 single strobe", m_valid, 0);
                if (exp_q.size() == 0) check(0, "R6 unexpected result", result, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(result == e, "R6 result", result, e);
                end
            end
            if (!m_sh && sh_n) begin in_wake = 1; wake_cnt = 1; end
            else if (in_wake) begin
                if (ready) begin
                    check(wake_cnt == WAKE, "R8 wake delay", wake_cnt, WAKE);
                    in_wake = 0;
                end else wake_cnt++;
            end
            cs_run = cs_n ? 0 : cs_run + 1;
            cv_run = cv_n ? 0 : cv_run + 1;
            rd_run = rd_n ? 0 : rd_run + 1;
            m_cv = cv_n; m_rd = rd_n; m_sh = sh_n; m_valid = valid;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic convert(input logic [13:0] s, input string req);
        int v0;
        v0 = n_valid;
        sample_next = s;
        pulse_start();
        for (int i = 0; i < 400 && n_valid == v0; i++) @(negedge clk);
        check(n_valid == v0 + 1, req, n_valid - v0, 1);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int s0;
        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({cs_n, cv_n, rd_n, sh_n} == 4'hF, "R1 pins idle", {cs_n, cv_n, rd_n, sh_n}, 15);
        check(ready && !err && !valid, "R1 status", {ready, err, valid}, 4);

        // R4 R6 conversions with several codes
        convert(14'h0123, "R4 conversion completes");
        convert(14'h2000, "R6 most negative");
        convert(14'h1FFF, "R6 most positive");
        convert(14'h3FFF, "R6 minus one");
        wait_cycles(1);
        check(ready, "R1 ready after conversion", ready, 1);

        // R10 start ignored mid-conversion
        s0 = n_starts;
        sample_next = 14'h0A5A;
        pulse_start();
        wait_cycles(20);
        check(!ready, "R10 not ready while converting", ready, 0);
        pulse_start();
        wait_cycles(300);
        check(n_starts == s0 + 1, "R10 extra start ignored", n_starts - s0, 1);

        // R7 nap, R10 start in power-down, R8 wake
        pmode = 2'd1;
        wait_cycles(20);
        check(!sh_n && !cs_n, "R7 nap pins", {sh_n, cs_n}, 0);
        s0 = n_starts;
        pulse_start();
        wait_cycles(10);
        check(n_starts == s0 && cv_n, "R10 start in nap ignored", n_starts - s0, 0);
        pmode = 2'd0;
        wait_cycles(5);
        pulse_start();
        wait_cycles(10);
        check(n_starts == s0, "R10 start during wake ignored", n_starts - s0, 0);
        wait_cycles(60);
        check(ready, "R8 ready after wake", ready, 1);
        convert(14'h1555, "R8 conversion after nap");

        // R7 sleep
        pmode = 2'd2;
        wait_cycles(20);
        check(!sh_n && cs_n, "R7 sleep pins", {sh_n, cs_n}, 1);
        pmode = 2'd0;
        wait_cycles(60);
        convert(14'h2ABC, "R8 conversion after sleep");

        // R9 timeout
        stuck = 1;
        s0 = n_valid;
        pulse_start();
        wait_cycles(230);
        check(err, "R9 error set", err, 1);
        check({cs_n, cv_n, rd_n, sh_n} == 4'hF, "R9 pins released",
              {cs_n, cv_n, rd_n, sh_n}, 15);
        check(ready && n_valid == s0, "R9 idle without result", n_valid - s0, 0);
        for (int i = 0; i < 400 && converting; i++) @(negedge clk);
        stuck = 0;
        wait_cycles(5);
        convert(14'h0042, "R9 recovers after timeout");
        check(err, "R9 error sticky", err, 1);
        check(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
        finish_run();
    end
endmodule